// File: doc/BRIEF.md
# Software-Managed MMU Register Front End

This block sits between a processor's special-register read/write port and the translation state of a software-managed MMU. Software reaches six registers through a 3-bit select: a process identifier, a zone protection word, an index register, a search register, and two entry windows. The tag window (HI) and the data window (LO) reach the entry that the index register points at. The block keeps the tag word, the data word and an 8-bit translation identifier for every entry.

Two window accesses have side effects. A HI write records the current process identifier as the entry's translation identifier. A HI read copies that entry's identifier back into the process identifier register. A write to the search register starts a lookup on the page-number part of the written value and holds off the processor port for a fixed number of cycles. An external lookup engine compares the page number against the exported tags. Its answer goes into the index register, with bit 31 flagging a miss.

Two configuration inputs decide which accesses are legal. A rejected access reads zero, changes nothing and raises a one-cycle error. A write that changes the process identifier or the zone word raises a one-cycle invalidate pulse for any translations held elsewhere.

Top module: `mmu_sreg_port`

## Requirements
- R1: After reset, stall, error and invalidate are low. Every register and every entry window reads zero.
- R2: The low log2(ENTRIES) bits of the index register select the entry reached through both windows. A LO write followed by a LO read of the same entry returns the written word. Other entries keep their own words.
- R3: A HI write stores the tag word. It also sets that entry's translation identifier (exported on `tlb_tid_flat`, 8 bits per entry, entry 0 lowest) to the current process identifier.
- R4: A HI read returns the selected tag word. It also loads the process identifier register with that entry's translation identifier.
- R5: A search write presents the written value with bits 9:0 cleared on `lk_vpn` and holds `sp_stall` high for exactly LOOKUP_LAT cycles. The index register then holds the hit entry number with bit 31 clear, or 32'h8000_0000 on a miss.
- R6: With `cfg_level` below 2 or `cfg_access` equal to 0, every access is rejected. A rejected read returns zero, a rejected write changes no state, and both pulse `sp_err` for one cycle.
- R7: Reads of select 2 (index), 3 (HI) and 4 (LO) need `cfg_access` bit 0. Reads of select 0 (process identifier), 1 (zone) and 5 (search) need no access bit.
- R8: Writes to select 0, 1 and 5 need `cfg_access` of 2 or more. Writes to selects 2, 3 and 4 need only the global enable of R6.
- R9: `inval_pulse` is high for one cycle after an accepted write to the process identifier or the zone register that changes its value. A write of the same value does not raise it.
- R10: Select codes 6 and 7 are rejected for reads and for writes.
- R11: An access presented while `sp_stall` is high is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level | input | 2 | MMU configuration level |
| cfg_access | input | 2 | Register access configuration |
| sp_en | input | 1 | Access request |
| sp_we | input | 1 | 1 = write, 0 = read |
| sp_sel | input | 3 | Register select (0 pid, 1 zone, 2 index, 3 HI, 4 LO, 5 search) |
| sp_wdata | input | 32 | Write data |
| sp_rdata | output | 32 | Read data, valid the cycle after the access |
| sp_err | output | 1 | Rejected-access pulse |
| sp_stall | output | 1 | Search in progress, access not taken |
| inval_pulse | output | 1 | Cached translations must be dropped |
| lk_vpn | output | 32 | Page number under search |
| lk_pid | output | 8 | Process identifier for the lookup |
| lk_hit | input | 1 | Lookup engine hit |
| lk_idx | input | IDX_W | Lookup engine hit entry |
| tlb_tag_flat | output | ENTRIES*32 | All tag words |
| tlb_tid_flat | output | ENTRIES*8 | All translation identifiers |

## Verification
An access is driven between clock edges and taken on the next rising edge. Read data, error and invalidate are due one cycle later, and the bench samples them at the following falling edge. A search raises stall at that same sample point. The bench counts the falling edges with stall high, expects exactly LOOKUP_LAT of them, and reads the index register only after stall drops. Each sampled value is compared with a behavioural model that the bench updates only for accesses it judges legal.

// File: rtl/mmu_sreg_pkg.sv
package mmu_sreg_pkg;
  localparam int DATA_W   = 32;
  localparam int PID_W    = 8;
  localparam int PAGE_LSB = 10;

  typedef enum logic [2:0] {
    SEL_PID    = 3'd0,
    SEL_ZONE   = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_HI     = 3'd3,
    SEL_LO     = 3'd4,
    SEL_SEARCH = 3'd5
  } sel_e;
endpackage

// File: rtl/mmu_rst_sync.sv
module mmu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/mmu_acc_gate.sv
module mmu_acc_gate
  import mmu_sreg_pkg::*;
(
  input  logic [1:0] cfg_level,
  input  logic [1:0] cfg_access,
  input  logic       we,
  input  logic [2:0] sel,
  output logic       ok
);
  logic glob_ok;
  logic wr_priv;

  assign glob_ok = (cfg_level >= 2'd2) && (cfg_access != 2'd0);
  assign wr_priv = (cfg_access >= 2'd2);

  always_comb begin
    ok = 1'b0;
    case (sel)
      SEL_PID, SEL_ZONE, SEL_SEARCH: ok = we ? wr_priv : 1'b1;
      SEL_INDEX, SEL_HI, SEL_LO:     ok = we ? 1'b1 : cfg_access[0];
      default:                       ok = 1'b0;
    endcase
    ok = ok && glob_ok;
  end
endmodule

// File: rtl/mmu_entry_store.sv
module mmu_entry_store
  import mmu_sreg_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [IDX_W-1:0]           sel_idx,
  input  logic                       hi_we,
  input  logic                       lo_we,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [PID_W-1:0]           pid_in,
  output logic [DATA_W-1:0]          hi_rd,
  output logic [DATA_W-1:0]          lo_rd,
  output logic [PID_W-1:0]           tid_rd,
  output logic [ENTRIES*DATA_W-1:0]  tag_flat,
  output logic [ENTRIES*PID_W-1:0]   tid_flat
);
  logic [DATA_W-1:0] tag_q [ENTRIES];
  logic [DATA_W-1:0] dat_q [ENTRIES];
  logic [PID_W-1:0]  tid_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic              hit_sel;
    logic [DATA_W-1:0] tag_d, dat_d;
    logic [PID_W-1:0]  tid_d;

    assign hit_sel = (sel_idx == IDX_W'(i));

    always_comb begin
      tag_d = tag_q[i];
      tid_d = tid_q[i];
      dat_d = dat_q[i];
      if (hi_we && hit_sel) begin
        tag_d = wdata;
        tid_d = pid_in;
      end
      if (lo_we && hit_sel) dat_d = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[i] <= '0;
        dat_q[i] <= '0;
        tid_q[i] <= '0;
      end else begin
        tag_q[i] <= tag_d;
        dat_q[i] <= dat_d;
        tid_q[i] <= tid_d;
      end
    end

    assign tag_flat[i*DATA_W +: DATA_W] = tag_q[i];
    assign tid_flat[i*PID_W +: PID_W]   = tid_q[i];

    // R3
    tid_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && hit_sel) |=> (tid_q[i] == $past(pid_in)));
  end

  assign hi_rd  = tag_q[sel_idx];
  assign lo_rd  = dat_q[sel_idx];
  assign tid_rd = tid_q[sel_idx];
endmodule

// File: rtl/mmu_search_ctl.sv
module mmu_search_ctl
  import mmu_sreg_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int LOOKUP_LAT = 3,
  localparam int IDX_W     = $clog2(ENTRIES),
  localparam int CNT_W     = (LOOKUP_LAT > 1) ? $clog2(LOOKUP_LAT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] wdata,
  input  logic              lk_hit,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic [DATA_W-1:0] lk_vpn,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_LSB) - DATA_W'(1));

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] vpn_q, vpn_d;

  assign done = busy_q && (cnt_q == '0);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    vpn_d  = vpn_q;
    if (start) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(LOOKUP_LAT - 1);
      vpn_d  = wdata & PAGE_MASK;
    end else if (done) begin
      busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      vpn_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      vpn_q  <= vpn_d;
    end
  end

  assign busy   = busy_q;
  assign lk_vpn = vpn_q;
  assign result = {~lk_hit, {(DATA_W-1-IDX_W){1'b0}}, (lk_hit ? lk_idx : IDX_W'(0))};

  // R5
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q);
  // R5
  vpn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done) |=> (busy_q && $stable(vpn_q)));
endmodule

// File: rtl/mmu_sreg_port.sv
module mmu_sreg_port
  import mmu_sreg_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int LOOKUP_LAT = 3,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 cfg_level,
  input  logic [1:0]                 cfg_access,
  input  logic                       sp_en,
  input  logic                       sp_we,
  input  logic [2:0]                 sp_sel,
  input  logic [31:0]                sp_wdata,
  output logic [31:0]                sp_rdata,
  output logic                       sp_err,
  output logic                       sp_stall,
  output logic                       inval_pulse,
  output logic [31:0]                lk_vpn,
  output logic [7:0]                 lk_pid,
  input  logic                       lk_hit,
  input  logic [IDX_W-1:0]           lk_idx,
  output logic [ENTRIES*32-1:0]      tlb_tag_flat,
  output logic [ENTRIES*8-1:0]       tlb_tid_flat
);
  logic rst_s;
  logic acc, ok, wr_ok, rd_ok;
  logic busy, done;
  logic [DATA_W-1:0] hi_rd, lo_rd, srch_res;
  logic [PID_W-1:0]  tid_rd;

  logic [PID_W-1:0]  pid_q, pid_d;
  logic [DATA_W-1:0] zone_q, zone_d;
  logic [DATA_W-1:0] index_q, index_d;
  logic [DATA_W-1:0] srch_q, srch_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              err_q, err_d;
  logic              inval_q, inval_d;
  logic [DATA_W-1:0] rmux;

  mmu_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s));

  mmu_acc_gate u_gate (
    .cfg_level(cfg_level), .cfg_access(cfg_access),
    .we(sp_we), .sel(sp_sel), .ok(ok)
  );

  assign acc   = sp_en && !busy;
  assign wr_ok = acc && ok && sp_we;
  assign rd_ok = acc && ok && !sp_we;

  mmu_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_s),
    .sel_idx(index_q[IDX_W-1:0]),
    .hi_we(wr_ok && (sp_sel == SEL_HI)),
    .lo_we(wr_ok && (sp_sel == SEL_LO)),
    .wdata(sp_wdata), .pid_in(pid_q),
    .hi_rd(hi_rd), .lo_rd(lo_rd), .tid_rd(tid_rd),
    .tag_flat(tlb_tag_flat), .tid_flat(tlb_tid_flat)
  );

  mmu_search_ctl #(.ENTRIES(ENTRIES), .LOOKUP_LAT(LOOKUP_LAT)) u_search (
    .clk(clk), .rst_n(rst_s),
    .start(wr_ok && (sp_sel == SEL_SEARCH)),
    .wdata(sp_wdata), .lk_hit(lk_hit), .lk_idx(lk_idx),
    .lk_vpn(lk_vpn), .busy(busy), .done(done), .result(srch_res)
  );

  always_comb begin
    case (sp_sel)
      SEL_PID:    rmux = {{(DATA_W-PID_W){1'b0}}, pid_q};
      SEL_ZONE:   rmux = zone_q;
      SEL_INDEX:  rmux = index_q;
      SEL_HI:     rmux = hi_rd;
      SEL_LO:     rmux = lo_rd;
      SEL_SEARCH: rmux = srch_q;
      default:    rmux = '0;
    endcase
  end

  always_comb begin
    pid_d   = pid_q;
    zone_d  = zone_q;
    index_d = index_q;
    srch_d  = srch_q;
    inval_d = 1'b0;
    rdata_d = rd_ok ? rmux : '0;
    err_d   = acc && !ok;
    if (done) index_d = srch_res;
    if (rd_ok && (sp_sel == SEL_HI)) pid_d = tid_rd;
    if (wr_ok) begin
      case (sp_sel)
        SEL_PID: begin
          pid_d   = sp_wdata[PID_W-1:0];
          inval_d = (sp_wdata[PID_W-1:0] != pid_q);
        end
        SEL_ZONE: begin
          zone_d  = sp_wdata;
          inval_d = (sp_wdata != zone_q);
        end
        SEL_INDEX:  index_d = sp_wdata;
        SEL_SEARCH: srch_d  = sp_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      pid_q   <= '0;
      zone_q  <= '0;
      index_q <= '0;
      srch_q  <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      inval_q <= 1'b0;
    end else begin
      pid_q   <= pid_d;
      zone_q  <= zone_d;
      index_q <= index_d;
      srch_q  <= srch_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      inval_q <= inval_d;
    end
  end

  assign sp_rdata    = rdata_q;
  assign sp_err      = err_q;
  assign sp_stall    = busy;
  assign inval_pulse = inval_q;
  assign lk_pid      = pid_q;

  // R6
  glob_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (sp_en && !sp_stall && ((cfg_level < 2'd2) || (cfg_access == 2'd0)))
      |=> (sp_err && (sp_rdata == '0)));
  // R10
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (sp_en && !sp_stall && (sp_sel > 3'd5)) |=> sp_err);
  // R9
  inval_src_chk: assert property (@(posedge clk) disable iff (!rst_s)
    inval_pulse |-> $past(sp_en && !sp_stall && sp_we &&
                          ((sp_sel == SEL_PID) || (sp_sel == SEL_ZONE))));
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (sp_stall && sp_en) |=> ($stable(pid_q) && $stable(zone_q) && $stable(tlb_tag_flat)));
endmodule

// File: tb/sim_mmu_sreg_port.sv
module sim_mmu_sreg_port;
  localparam int PERIOD  = 10;
  localparam int ENTRIES = 16;
  localparam int LAT     = 3;
  localparam int IW      = $clog2(ENTRIES);

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] cfg_level, cfg_access;
  logic sp_en, sp_we;
  logic [2:0] sp_sel;
  logic [31:0] sp_wdata, sp_rdata, lk_vpn;
  logic sp_err, sp_stall, inval_pulse, lk_hit;
  logic [7:0] lk_pid;
  logic [IW-1:0] lk_idx;
  logic [ENTRIES*32-1:0] tag_flat;
  logic [ENTRIES*8-1:0]  tid_flat;

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  // reference model state
  logic [31:0] m_tag [ENTRIES];
  logic [31:0] m_lo  [ENTRIES];
  logic [7:0]  m_tid [ENTRIES];
  logic [7:0]  m_pid;
  logic [31:0] m_zone, m_idx, m_srch;

  always #(PERIOD/2) clk = ~clk;

  mmu_sreg_port #(.ENTRIES(ENTRIES), .LOOKUP_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .cfg_access(cfg_access),
    .sp_en(sp_en), .sp_we(sp_we), .sp_sel(sp_sel), .sp_wdata(sp_wdata),
    .sp_rdata(sp_rdata), .sp_err(sp_err), .sp_stall(sp_stall),
    .inval_pulse(inval_pulse), .lk_vpn(lk_vpn), .lk_pid(lk_pid),
    .lk_hit(lk_hit), .lk_idx(lk_idx),
    .tlb_tag_flat(tag_flat), .tlb_tid_flat(tid_flat)
  );

  // lookup engine stand-in: valid bit 6, page bits 31:10, tid 0 = global
  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (tag_flat[i*32+6] && (tag_flat[i*32+10 +: 22] == lk_vpn[31:10]) &&
          ((tid_flat[i*8 +: 8] == 8'h00) || (tid_flat[i*8 +: 8] == lk_pid))) begin
        lk_hit = 1'b1;
        lk_idx = IW'(i);
      end
    end
  end

  task automatic chk(input bit good, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input bit we, input int sel);
    if (cfg_level < 2 || cfg_access == 0) return 0;
    if (sel == 0 || sel == 1 || sel == 5) return we ? (cfg_access >= 2) : 1'b1;
    if (sel >= 2 && sel <= 4) return we ? 1'b1 : cfg_access[0];
    return 0;
  endfunction

  task automatic do_acc(input bit we, input int sel, input logic [31:0] wd,
                        input string req, input bit intrude = 0);
    bit ok;
    int e;
    logic [31:0] exp_rd, exp_res;
    bit exp_inv, is_srch;
    int n;
    @(negedge clk);
    sp_en = 1'b1; sp_we = we; sp_sel = sel[2:0]; sp_wdata = wd;
    ok = legal(we, sel);
    e = int'(m_idx[IW-1:0]);
    exp_rd = '0; exp_inv = 0; is_srch = 0; exp_res = 32'h8000_0000;
    if (ok && !we) begin
      case (sel)
        0: exp_rd = {24'h0, m_pid};
        1: exp_rd = m_zone;
        2: exp_rd = m_idx;
        3: exp_rd = m_tag[e];
        4: exp_rd = m_lo[e];
        5: exp_rd = m_srch;
        default: exp_rd = '0;
      endcase
      if (sel == 3) m_pid = m_tid[e];
    end
    if (ok && we) begin
      case (sel)
        0: begin exp_inv = (wd[7:0] != m_pid); m_pid = wd[7:0]; end
        1: begin exp_inv = (wd != m_zone); m_zone = wd; end
        2: m_idx = wd;
        3: begin m_tag[e] = wd; m_tid[e] = m_pid; end
        4: m_lo[e] = wd;
        5: begin
          m_srch = wd; is_srch = 1;
          for (int i = 0; i < ENTRIES; i++) begin
            if (exp_res[31] && m_tag[i][6] && (m_tag[i][31:10] == wd[31:10]) &&
                (m_tid[i] == 8'h00 || m_tid[i] == m_pid))
              exp_res = i;
          end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    sp_en = 1'b0;
    chk(sp_rdata == exp_rd, req, "rdata", sp_rdata, exp_rd);
    chk(sp_err == !ok, req, "err", {31'h0, sp_err}, {31'h0, !ok});
    chk(inval_pulse == exp_inv, req, "inval", {31'h0, inval_pulse}, {31'h0, exp_inv});
    chk(sp_stall == is_srch, req, "stall", {31'h0, sp_stall}, {31'h0, is_srch});
    if (ok && we && sel == 3)
      chk(tid_flat[e*8 +: 8] == m_tid[e], req, "tid", {24'h0, tid_flat[e*8 +: 8]}, {24'h0, m_tid[e]});
    if (is_srch) begin
      chk(lk_vpn == (wd & 32'hFFFF_FC00), req, "lk_vpn", lk_vpn, wd & 32'hFFFF_FC00);
      n = 1;
      if (intrude) begin
        sp_en = 1'b1; sp_we = 1'b1; sp_sel = 3'd0; sp_wdata = 32'h77;
      end
      forever begin
        @(negedge clk);
        sp_en = 1'b0;
        if (sp_stall) n++;
        else break;
        if (n > LAT + 5) break;
      end
      chk(n == LAT, req, "stall cycles", n, LAT);
      m_idx = exp_res;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin m_tag[i] = '0; m_lo[i] = '0; m_tid[i] = '0; end
    m_pid = '0; m_zone = '0; m_idx = '0; m_srch = '0;
    rst_n = 1'b0; sp_en = 1'b0; sp_we = 1'b0; sp_sel = '0; sp_wdata = '0;
    cfg_level = 2'd3; cfg_access = 2'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!sp_stall && !sp_err && !inval_pulse, "R1", "flags", {29'h0, sp_stall, sp_err, inval_pulse}, 0);
    for (int s = 0; s < 6; s++) do_acc(0, s, 0, "R1");

    // R8 R9 pid write, repeat same value
    do_acc(1, 0, 32'h15, "R9");
    do_acc(1, 0, 32'h15, "R9");
    // R2 R3 fill entry 5
    do_acc(1, 2, 32'd5, "R2");
    do_acc(1, 3, 32'h1234_5440, "R3");
    do_acc(1, 4, 32'hABCD_0001, "R2");
    do_acc(0, 4, 0, "R2");
    // entry 9, global tag (tid 0 at pid 0)
    do_acc(1, 0, 32'h00, "R9");
    do_acc(1, 2, 32'd9, "R2");
    do_acc(0, 4, 0, "R2");
    do_acc(1, 3, 32'h0001_0040, "R3");
    // R4 read HI of entry 5 loads pid 0x15
    do_acc(1, 2, 32'd5, "R4");
    do_acc(0, 3, 0, "R4");
    do_acc(0, 0, 0, "R4");
    // R5 search hit entry 5, miss, global hit with pid mismatch
    do_acc(1, 5, 32'h1234_57FF, "R5");
    do_acc(0, 2, 0, "R5");
    do_acc(1, 0, 32'h22, "R5");
    do_acc(1, 5, 32'h1234_5400, "R5");
    do_acc(0, 2, 0, "R5");
    do_acc(1, 5, 32'h0001_0123, "R5");
    do_acc(0, 2, 0, "R5");
    do_acc(0, 5, 0, "R7");
    // R11 access during stall not taken
    do_acc(1, 5, 32'h0, "R11", 1);
    do_acc(0, 0, 0, "R11");
    // R9 zone
    do_acc(1, 1, 32'h5555_0000, "R9");
    do_acc(1, 1, 32'h5555_0000, "R9");
    // R8 access 1: priv writes rejected, window writes allowed
    cfg_access = 2'd1;
    do_acc(1, 1, 32'h1, "R8");
    do_acc(1, 0, 32'h3, "R8");
    do_acc(1, 5, 32'h0, "R8");
    do_acc(0, 1, 0, "R8");
    do_acc(1, 4, 32'h0BAD_F00D, "R8");
    // R7 access 2: window reads rejected
    cfg_access = 2'd2;
    do_acc(0, 2, 0, "R7");
    do_acc(0, 3, 0, "R7");
    do_acc(0, 4, 0, "R7");
    do_acc(0, 0, 0, "R7");
    // R6 level below 2, then access 0
    cfg_access = 2'd3; cfg_level = 2'd1;
    do_acc(0, 0, 0, "R6");
    do_acc(1, 2, 32'd3, "R6");
    cfg_level = 2'd2; cfg_access = 2'd0;
    do_acc(1, 4, 32'h1, "R6");
    cfg_access = 2'd3;
    do_acc(0, 2, 0, "R6");
    do_acc(0, 4, 0, "R6");
    // R10 undefined selects
    do_acc(0, 6, 0, "R10");
    do_acc(1, 7, 32'hFFFF_FFFF, "R10");
    do_acc(0, 1, 0, "R10");

    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    end
    $finish;
  end
endmodule